// File: doc/BRIEF.md
# Sync-Referenced Noise Gate Window

This block produces a gate that marks, inside every video line, the span during which phase comparison is blocked. It follows an active-low composite sync input, restarts a pixel-clock counter on each falling edge of that input, closes the gate when the count reaches a programmed close offset and reopens it at a programmed open offset. When the close offset lies later than the open offset, the closed span wraps across the line boundary.

The two offsets are 12-bit codes. A code of c places the event c+1 clocks after the sync edge. Each code is loaded through an 8-bit register port with one address per byte. A low-byte write only fills a staging byte. The whole code is committed in the cycle its high byte is written. If the close code is placed beyond the line length and the open code inside it, the gate never closes, which is the wideband mode. Equal codes hold the gate closed from the shared offset onward.

Top module: `sync_gate_window`

## Requirements
- R1: After reset both codes read as zero and `gate_open` is 1. It stays 1, whatever the codes, until the first falling edge of `csync_n` is seen.
- R2: Suppose `csync_n` is driven low before a rising clock edge, which is counted as edge 1, after being high. The gate then closes (`gate_open` = 0) at rising edge c+4, where c is the close code. It is still unchanged after edge c+3.
- R3: The gate reopens (`gate_open` = 1) at rising edge p+4, where p is the open code, counted in the same way.
- R4: When the close code is larger than the open code, the gate stays closed across the next sync edge and reopens at that line's open offset.
- R5: When the two codes are equal, the gate closes at the shared offset and does not reopen on later lines while the codes stay equal.
- R6: When the close code is beyond the line length and the open code is within it, `gate_open` stays 1 throughout the line.
- R7: A write to a low-byte address (0 = close low, 2 = open low) changes neither the committed code nor its readback. Reads of a low address return bits 7:0 of the committed code.
- R8: A write to a high-byte address (1 = close high, 3 = open high) commits {wdata[3:0], staged low byte} as the 12-bit code. Bits 7:4 of the written byte are discarded, and reads of a high address return 0 in bits 7:4.
- R9: The line counter saturates and does not wrap. On a line longer than the counter range, no offset matches a second time.
- R10: A code committed in the middle of a line takes part in compares from the next clock on. An offset the line has already passed causes no retroactive change of the gate.
- R11: The close and open codes have separate staging bytes. Interleaved writes to the two codes commit each code correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| csync_n | input | 1 | Active-low composite sync, asynchronous to clk |
| cpu_we | input | 1 | Register write strobe, one byte per cycle |
| cpu_addr | input | 2 | Byte address: 0 close low, 1 close high, 2 open low, 3 open high |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Readback of the committed byte at `cpu_addr` |
| gate_open | output | 1 | 1 = comparisons allowed, 0 = gate closed |

## Verification
Counter saturation is the hardest case to reach from the ports. It shows only when a line runs past the whole counter range without a sync edge, and then only if the gate state at that point would differ from the state a wrapped counter produces. The stimulus programs an early close and a late reopen, so the gate is open for most of the line. It then withholds sync for more than 9000 clocks and samples in the window where a wrapped count would have closed the gate again. The mid-line update case gets its own stimulus: it commits a close offset the line has already passed, then commits one it has not yet reached.

// File: rtl/ngw_pkg.sv
package ngw_pkg;

    // Width of an offset code and of the register port
    parameter int NGW_VAL_W  = 12;
    parameter int NGW_BYTE_W = 8;
    // Default line counter width, one bit wider than the code
    parameter int NGW_CNT_W  = 13;
    parameter int NGW_HI_W   = NGW_VAL_W - NGW_BYTE_W;

    // Byte address map: bit 1 selects the code, bit 0 selects the high byte
    typedef enum logic [1:0] {
        ADDR_CLOSE_LO = 2'd0,
        ADDR_CLOSE_HI = 2'd1,
        ADDR_OPEN_LO  = 2'd2,
        ADDR_OPEN_HI  = 2'd3
    } ngw_addr_e;

    localparam int CODE_CLOSE = 0;
    localparam int CODE_OPEN  = 1;
    localparam int NUM_CODES  = 2;

    typedef struct packed {
        logic [NGW_VAL_W-1:0] close_code;
        logic [NGW_VAL_W-1:0] open_code;
    } ngw_cfg_t;

    typedef struct packed {
        logic hit_close;
        logic hit_open;
    } ngw_hits_t;

    // Returns 1 when the address names a high byte (commit point)
    function automatic logic is_high_byte(input logic [1:0] addr);
        return addr[0];
    endfunction

    // Returns the index of the code selected by an address
    function automatic int code_index(input logic [1:0] addr);
        return addr[1] ? CODE_OPEN : CODE_CLOSE;
    endfunction

endpackage

// File: rtl/ngw_sync_edge.sv
module ngw_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic csync_n,
    output logic sync_fall
);
    localparam int CHAIN_LEN = SYNC_STAGES + 1;

    // chain[0..SYNC_STAGES-1] synchronize, chain[SYNC_STAGES] holds the previous sample
    logic [CHAIN_LEN-1:0] chain_q;

    generate
        for (genvar g = 0; g < CHAIN_LEN; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b1;
                    else     chain_q[g] <= csync_n;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b1;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_fall = chain_q[SYNC_STAGES] & ~chain_q[SYNC_STAGES-1];

endmodule

// File: rtl/ngw_line_counter.sv
module ngw_line_counter #(
    parameter int CNT_W = ngw_pkg::NGW_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_fall,
    output logic [CNT_W-1:0] line_cnt
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (sync_fall) begin
            cnt_q <= CNT_ONE;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + CNT_ONE;
        end
    end

    assign line_cnt = cnt_q;

    // The count restarts at one after each detected sync edge
    assert_restart_R2: assert property (@(posedge clk) disable iff (rst)
        sync_fall |=> (line_cnt == CNT_ONE));

    // The count holds at full scale until the next sync edge
    assert_no_wrap_R9: assert property (@(posedge clk) disable iff (rst)
        (line_cnt == CNT_MAX && !sync_fall) |=> (line_cnt == CNT_MAX));

endmodule

// File: rtl/ngw_regs.sv
module ngw_regs
    import ngw_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cpu_we,
    input  logic [1:0]            cpu_addr,
    input  logic [NGW_BYTE_W-1:0] cpu_wdata,
    output logic [NGW_BYTE_W-1:0] cpu_rdata,
    output ngw_cfg_t              cfg
);
    localparam int PAD_W = NGW_BYTE_W - NGW_HI_W;

    logic [NGW_VAL_W-1:0]  code_q  [NUM_CODES];
    logic [NGW_BYTE_W-1:0] stage_q [NUM_CODES];
    logic                  unused_wdata_hi;

    assign unused_wdata_hi = ^cpu_wdata[NGW_BYTE_W-1:NGW_HI_W];

    generate
        for (genvar g = 0; g < NUM_CODES; g++) begin : g_code
            logic sel;
            assign sel = cpu_we && (code_index(cpu_addr) == g);

            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q[g] <= '0;
                    code_q[g]  <= '0;
                end else if (sel) begin
                    if (is_high_byte(cpu_addr)) begin
                        code_q[g] <= {cpu_wdata[NGW_HI_W-1:0], stage_q[g]};
                    end else begin
                        stage_q[g] <= cpu_wdata;
                    end
                end
            end
        end
    endgenerate

    always_comb begin
        logic [NGW_VAL_W-1:0] sel_code;
        sel_code = code_q[code_index(cpu_addr)];
        if (is_high_byte(cpu_addr)) begin
            cpu_rdata = {{PAD_W{1'b0}}, sel_code[NGW_VAL_W-1:NGW_BYTE_W]};
        end else begin
            cpu_rdata = sel_code[NGW_BYTE_W-1:0];
        end
    end

    assign cfg.close_code = code_q[CODE_CLOSE];
    assign cfg.open_code  = code_q[CODE_OPEN];

    // A low-byte write never moves a committed code
    assert_lo_stage_only_R7: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && !cpu_addr[0]) |=> $stable(cfg));

    // A high-byte write to one code leaves the other code alone
    assert_codes_separate_R11: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && cpu_addr == ADDR_CLOSE_HI) |=> $stable(cfg.open_code));

    // Upper nibble of a high-byte read is always zero
    assert_hi_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
        cpu_addr[0] |-> (cpu_rdata[NGW_BYTE_W-1:NGW_HI_W] == '0));

endmodule

// File: rtl/ngw_gate_ctrl.sv
module ngw_gate_ctrl
    import ngw_pkg::*;
#(
    parameter int CNT_W = NGW_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_fall,
    input  logic [CNT_W-1:0] line_cnt,
    input  ngw_cfg_t         cfg,
    output logic             gate_open
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    ngw_hits_t hits;
    logic      seen_q;
    logic      open_q;
    logic      codes_equal;

    // A code c matches count c+1
    assign hits.hit_close = (line_cnt == (CNT_W'(cfg.close_code) + CNT_ONE));
    assign hits.hit_open  = (line_cnt == (CNT_W'(cfg.open_code)  + CNT_ONE));
    assign codes_equal    = (cfg.close_code == cfg.open_code);

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 1'b0;
            open_q <= 1'b1;
        end else begin
            if (sync_fall) seen_q <= 1'b1;
            if (seen_q) begin
                // Closing wins so equal codes keep the gate shut
                if (hits.hit_close)     open_q <= 1'b0;
                else if (hits.hit_open) open_q <= 1'b1;
            end
        end
    end

    assign gate_open = open_q;

    assert_open_before_sync_R1: assert property (@(posedge clk) disable iff (rst)
        !seen_q |-> gate_open);

    assert_close_on_match_R2: assert property (@(posedge clk) disable iff (rst)
        (seen_q && hits.hit_close) |=> !gate_open);

    assert_open_on_match_R3: assert property (@(posedge clk) disable iff (rst)
        (seen_q && hits.hit_open && !hits.hit_close) |=> gate_open);

    assert_equal_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (!gate_open && codes_equal) |=> !gate_open);

endmodule

// File: rtl/sync_gate_window.sv
module sync_gate_window
    import ngw_pkg::*;
#(
    parameter int CNT_W       = NGW_CNT_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       csync_n,
    input  logic       cpu_we,
    input  logic [1:0] cpu_addr,
    input  logic [7:0] cpu_wdata,
    output logic [7:0] cpu_rdata,
    output logic       gate_open
);
    logic             sync_fall;
    logic [CNT_W-1:0] line_cnt;
    ngw_cfg_t         cfg;

    ngw_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst       (rst),
        .csync_n   (csync_n),
        .sync_fall (sync_fall)
    );

    ngw_line_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk       (clk),
        .rst       (rst),
        .sync_fall (sync_fall),
        .line_cnt  (line_cnt)
    );

    ngw_regs regs_i (
        .clk       (clk),
        .rst       (rst),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .cfg       (cfg)
    );

    ngw_gate_ctrl #(.CNT_W(CNT_W)) gate_i (
        .clk       (clk),
        .rst       (rst),
        .sync_fall (sync_fall),
        .line_cnt  (line_cnt),
        .cfg       (cfg),
        .gate_open (gate_open)
    );

endmodule

// File: tb/sync_gate_window_tb_top.sv
`timescale 1ns/1ps
module sync_gate_window_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       csync_n = 1'b1;
    logic       cpu_we = 1'b0;
    logic [1:0] cpu_addr = 2'd0;
    logic [7:0] cpu_wdata = 8'd0;
    logic [7:0] cpu_rdata;
    logic       gate_open;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sync_gate_window dut_i (
        .clk       (clk),
        .rst       (rst),
        .csync_n   (csync_n),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .gate_open (gate_open)
    );

    typedef struct packed {
        logic [11:0] close_c;
        logic [11:0] open_c;
        logic [15:0] wait_n;
        logic        exp_open;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{12'd10,   12'd40, 16'd50,  1'b1, 4'd3},  // R3 reopened
        '{12'd10,   12'd40, 16'd13,  1'b1, 4'd2},  // R2 one edge before close
        '{12'd10,   12'd40, 16'd14,  1'b0, 4'd2},  // R2 close edge
        '{12'd10,   12'd40, 16'd43,  1'b0, 4'd3},  // R3 one edge before open
        '{12'd10,   12'd40, 16'd44,  1'b1, 4'd3},  // R3 open edge
        '{12'd60,   12'd20, 16'd30,  1'b1, 4'd4},  // R4 open after stop
        '{12'd60,   12'd20, 16'd64,  1'b0, 4'd4},  // R4 closed late in line
        '{12'd60,   12'd20, 16'd10,  1'b0, 4'd4},  // R4 still closed after sync
        '{12'd60,   12'd20, 16'd24,  1'b1, 4'd4},  // R4 reopens
        '{12'd4000, 12'd20, 16'd300, 1'b1, 4'd6},  // R6 wideband
        '{12'd4000, 12'd20, 16'd10,  1'b1, 4'd6},  // R6 wideband early
        '{12'd30,   12'd30, 16'd40,  1'b0, 4'd5},  // R5 equal closes
        '{12'd30,   12'd30, 16'd20,  1'b0, 4'd5},  // R5 stays closed next line
        '{12'd30,   12'd30, 16'd60,  1'b0, 4'd5}   // R5 no reopen
    };

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        cpu_addr  = a;
        cpu_wdata = d;
        cpu_we    = 1'b1;
        cycles(1);
        cpu_we    = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string req);
        cpu_addr = a;
        #1;
        chk(req, {24'd0, cpu_rdata}, {24'd0, exp});
    endtask

    task automatic prog(input logic [11:0] c, input logic [11:0] p);
        wr(2'd0, c[7:0]);
        wr(2'd1, {4'h0, c[11:8]});
        wr(2'd2, p[7:0]);
        wr(2'd3, {4'h0, p[11:8]});
    endtask

    // Drive a sync edge, then let n rising edges pass in total
    task automatic sync_line(input int n);
        csync_n = 1'b0;
        cycles(3);
        csync_n = 1'b1;
        cycles(n - 3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        cycles(4);
        rst = 1'b0;
        cycles(1);

        // R1: reset state
        rd_chk(2'd0, 8'h00, "R1 close lo");
        rd_chk(2'd1, 8'h00, "R1 close hi");
        rd_chk(2'd2, 8'h00, "R1 open lo");
        rd_chk(2'd3, 8'h00, "R1 open hi");
        chk("R1 gate after reset", {31'd0, gate_open}, 32'd1);
        prog(12'd5, 12'd100);
        cycles(50);
        chk("R1 gate before first sync", {31'd0, gate_open}, 32'd1);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            prog(VEC[i].close_c, VEC[i].open_c);
            sync_line(int'(VEC[i].wait_n));
            checks++;
            if (gate_open !== VEC[i].exp_open) begin
                errors++;
                $display("FAIL R%0d vector %0d: actual %0b expected %0b",
                         VEC[i].req, i, gate_open, VEC[i].exp_open);
            end
        end

        // R7 and R8: staging and commit
        prog(12'h123, 12'h456);
        wr(2'd0, 8'hAB);
        rd_chk(2'd0, 8'h23, "R7 low write staged only");
        rd_chk(2'd1, 8'h01, "R7 high unchanged");
        wr(2'd1, 8'hF1);
        rd_chk(2'd1, 8'h01, "R8 high nibble dropped");
        rd_chk(2'd0, 8'hAB, "R8 low committed");

        // R11: interleaved staging
        wr(2'd0, 8'h12);
        wr(2'd2, 8'h34);
        wr(2'd3, 8'h05);
        wr(2'd1, 8'h06);
        rd_chk(2'd0, 8'h12, "R11 close lo");
        rd_chk(2'd1, 8'h06, "R11 close hi");
        rd_chk(2'd2, 8'h34, "R11 open lo");
        rd_chk(2'd3, 8'h05, "R11 open hi");

        // R10: mid-line updates
        prog(12'd300, 12'd10);
        sync_line(60);
        chk("R10 open before update", {31'd0, gate_open}, 32'd1);
        wr(2'd0, 8'd20);
        wr(2'd1, 8'd0);
        cycles(10);
        chk("R10 passed offset no effect", {31'd0, gate_open}, 32'd1);
        wr(2'd0, 8'd150);
        wr(2'd1, 8'd0);
        cycles(100);
        chk("R10 future offset closes", {31'd0, gate_open}, 32'd0);

        // R9: saturation on a very long line
        prog(12'd1, 12'd3000);
        sync_line(3100);
        chk("R9 open mid line", {31'd0, gate_open}, 32'd1);
        cycles(6000);
        chk("R9 no wrap rematch", {31'd0, gate_open}, 32'd1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule